// File: doc/BRIEF.md
# PCI Master Bus Command Selector

This block belongs to the DMA engine of a PCI bus master. Each time the engine wins the bus it has to choose the 4-bit memory command for the new ownership. The choice depends on the kind of transfer, the cache and command enable bits, the cache line size and burst size settings, the current address and the number of bytes still to move. It also depends on how the previous ownership ended. A read data transfer can be upgraded from a plain read to a line read. A write can be upgraded from a plain write to a write-and-invalidate.

The engine pulses `start` with the transfer context on the ports. One cycle later the block presents the command together with a flag that marks line-based commands.

When an ownership ends, the engine reports how it ended. A one-bit registered flag records that a write-and-invalidate was retried by the target. While that flag is set, the next write reissues write-and-invalidate. A disconnect gives no such guarantee: the resumed write is judged afresh, so it needs a line-aligned address.

Top module: `pciCmdSelect`

## Requirements
- R1: After reset `cmdValid` is low and stays low until a `start` pulse is accepted.
- R2: A `start` pulse sampled at a clock edge causes `cmdValid` to be high for exactly the following cycle, with `cmd` and `lineCmd` valid in that cycle.
- R3: An opcode fetch (`xferKind` = 2'b01) always yields Memory Read, 4'b0110, whatever the enable bits are.
- R4: With `cacheEn` low, a read data transfer (`xferKind` = 2'b00) yields Memory Read Line, 4'b1110, when `readLineEn` is high, and Memory Read, 4'b0110, otherwise.
- R5: With `cacheEn` high, a read data transfer yields 4'b1110 only when all three of these hold: `readLineEn` is high, the line size is legal, and the line size in dwords does not exceed the burst size 2^`burstLog2` dwords. Otherwise it yields 4'b0110.
- R6: The only legal values of `lineSizeDw` are 2, 4, 8, 16, 32, 64 and 128. Any other value disables both line commands.
- R7: A write (`xferKind` = 2'b1x) yields Memory Write and Invalidate, 4'b1111, when five conditions hold: `cacheEn` is high, `wrInvEn` is high, the line size is legal, `addr` is a multiple of 4*`lineSizeDw` bytes, and `bytesLeft` is at least 4*`lineSizeDw`. Otherwise it yields Memory Write, 4'b0111.
- R8: An ownership end reported as a target retry (`endKind` = 2'b01) after a 4'b1111 command forces the next write to 4'b1111, even if it fails R7.
- R9: An ownership end reported as a disconnect (`endKind` = 2'b10) forces nothing. The next write gets 4'b1111 only if it meets R7, which includes a line-aligned address.
- R10: The retry flag is cleared by a normal completion (`endKind` = 2'b00) and by a `newXfer` pulse. `newXfer` wins when both occur in the same cycle.
- R11: `lineCmd` is high exactly when the issued command is 4'b1110 or 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | New bus ownership: choose a command |
| newXfer | input | 1 | A new transfer begins; clears the retry flag |
| xferKind | input | 2 | 00 read data, 01 opcode fetch, 1x write |
| cacheEn | input | 1 | Cache mode enable |
| readLineEn | input | 1 | Read-line enable |
| wrInvEn | input | 1 | Write-and-invalidate enable |
| lineSizeDw | input | 8 | Cache line size in dwords |
| burstLog2 | input | 3 | DMA burst size as log2 of dwords |
| addr | input | 32 | Byte address of the ownership |
| bytesLeft | input | 24 | Bytes still to transfer |
| endValid | input | 1 | Ownership-end report strobe |
| endKind | input | 2 | 00 completed, 01 target retry, 10 disconnect |
| cmdValid | output | 1 | Command valid, one cycle |
| cmd | output | 4 | Bus command code |
| lineCmd | output | 1 | Command is cache-line based |

## Verification
The hardest state to reach from the ports is the forced reissue. It requires a write-and-invalidate to be issued, a retry to be reported against it, and then a write that on its own merits would be a plain write. The stimulus sets this up with a misaligned address and a short byte count. The same write is then repeated after a completion, after a `newXfer` pulse, and after a retry that followed a plain write. This shows the flag is set only by the right history and is cleared at the right points. Line-size legality and the burst bound are covered by walking the boundaries: sizes 1 and 6, size equal to the burst, and size one step above it.

// File: rtl/pci_cmd_pkg.sv
package pci_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_MEM_READ      = 4'b0110,
    CMD_MEM_READ_LINE = 4'b1110,
    CMD_MEM_WRITE     = 4'b0111,
    CMD_MEM_WRITE_INV = 4'b1111
  } busCmdT;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_FETCH = 2'b01;

  localparam logic [1:0] END_DONE  = 2'b00;
  localparam logic [1:0] END_RETRY = 2'b01;
  localparam logic [1:0] END_DISC  = 2'b10;

  // Qualifiers computed by the datapath for the control.
  typedef struct packed {
    logic lineLegal;
    logic fitsBurst;
    logic aligned;
    logic fullLine;
  } qualT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   load;
    busCmdT sel;
  } strobeT;

endpackage

// File: rtl/pciCmdDatapath.sv
module pciCmdDatapath
  import pci_cmd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 24,
  parameter int LSZ_W         = 8,
  parameter int BURST_W       = 3,
  parameter int MAX_LINE_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LSZ_W-1:0]   lineSizeDw,
  input  logic [BURST_W-1:0] burstLog2,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   bytesLeft,
  input  strobeT             strobe,
  output qualT               qual,
  output logic               cmdValid,
  output logic [3:0]         cmd,
  output logic               lineCmd
);

  localparam int LOG_W = $clog2(MAX_LINE_LOG2 + 1);

  logic [MAX_LINE_LOG2:0] sizeHit;
  logic [LOG_W-1:0]       lineLog2;
  logic [ADDR_W-1:0]      lineMask;
  logic [CNT_W-1:0]       lineBytes;

  // One comparator per legal power of two (2 .. 2^MAX_LINE_LOG2 dwords).
  assign sizeHit[0] = 1'b0;
  for (genvar i = 1; i <= MAX_LINE_LOG2; i++) begin : g_size
    assign sizeHit[i] = (lineSizeDw == LSZ_W'(1 << i));
  end

  always_comb begin
    lineLog2 = '0;
    for (int i = 1; i <= MAX_LINE_LOG2; i++) begin
      if (sizeHit[i]) lineLog2 = lineLog2 | LOG_W'(i);
    end
  end

  assign lineMask  = (ADDR_W'(lineSizeDw) << 2) - ADDR_W'(1);
  assign lineBytes = CNT_W'(lineSizeDw) << 2;

  assign qual.lineLegal = |sizeHit;
  assign qual.fitsBurst = qual.lineLegal && (int'(lineLog2) <= int'(burstLog2));
  assign qual.aligned   = ((addr & lineMask) == '0);
  assign qual.fullLine  = (bytesLeft >= lineBytes);

  // Output register: one cycle after the load strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmd      <= CMD_MEM_READ;
      lineCmd  <= 1'b0;
    end else begin
      cmdValid <= strobe.load;
      if (strobe.load) begin
        cmd     <= strobe.sel;
        lineCmd <= (strobe.sel == CMD_MEM_READ_LINE) || (strobe.sel == CMD_MEM_WRITE_INV);
      end
    end
  end

  a_r2_valid_after_load: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(strobe.load));

  a_r6_legal_size_set: assert property (@(posedge clk) disable iff (!rstN)
    qual.lineLegal |-> ($onehot(lineSizeDw) && !lineSizeDw[0] && (int'(lineSizeDw) <= 128)));

  a_r11_line_flag: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (lineCmd == (cmd == 4'b1110 || cmd == 4'b1111)));

endmodule

// File: rtl/pciCmdControl.sv
module pciCmdControl
  import pci_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       newXfer,
  input  logic [1:0] xferKind,
  input  logic       cacheEn,
  input  logic       readLineEn,
  input  logic       wrInvEn,
  input  qualT       qual,
  input  logic       endValid,
  input  logic [1:0] endKind,
  output strobeT     strobe
);

  logic   retryPend;
  logic   lastInv;
  logic   isWrite;
  logic   isFetch;
  logic   readLineOk;
  logic   invOk;
  busCmdT selCmd;

  assign isWrite = xferKind[1];
  assign isFetch = (xferKind == KIND_FETCH);

  // Without cache mode the enable alone decides; with it, size rules apply.
  assign readLineOk = readLineEn && (!cacheEn || (qual.lineLegal && qual.fitsBurst));
  assign invOk      = cacheEn && wrInvEn && qual.lineLegal && qual.aligned && qual.fullLine;

  always_comb begin
    if (isWrite)      selCmd = (retryPend || invOk) ? CMD_MEM_WRITE_INV : CMD_MEM_WRITE;
    else if (isFetch) selCmd = CMD_MEM_READ;
    else              selCmd = readLineOk ? CMD_MEM_READ_LINE : CMD_MEM_READ;
  end

  assign strobe.load = start;
  assign strobe.sel  = selCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryPend <= 1'b0;
      lastInv   <= 1'b0;
    end else begin
      if (start) lastInv <= (selCmd == CMD_MEM_WRITE_INV);
      if (newXfer)       retryPend <= 1'b0;
      else if (endValid) retryPend <= (endKind == END_RETRY) && lastInv;
    end
  end

  a_r8_retry_arms: assert property (@(posedge clk) disable iff (!rstN)
    (endValid && endKind == END_RETRY && lastInv && !newXfer) |=> retryPend);

  a_r10_newxfer_clears: assert property (@(posedge clk) disable iff (!rstN)
    newXfer |=> !retryPend);

  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (endValid && endKind == END_DONE) |=> !retryPend);

  a_r9_disc_no_force: assert property (@(posedge clk) disable iff (!rstN)
    (endValid && endKind == END_DISC) |=> !retryPend);

endmodule

// File: rtl/pciCmdSelect.sv
module pciCmdSelect
  import pci_cmd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 24,
  parameter int LSZ_W         = 8,
  parameter int BURST_W       = 3,
  parameter int MAX_LINE_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               newXfer,
  input  logic [1:0]         xferKind,
  input  logic               cacheEn,
  input  logic               readLineEn,
  input  logic               wrInvEn,
  input  logic [LSZ_W-1:0]   lineSizeDw,
  input  logic [BURST_W-1:0] burstLog2,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   bytesLeft,
  input  logic               endValid,
  input  logic [1:0]         endKind,
  output logic               cmdValid,
  output logic [3:0]         cmd,
  output logic               lineCmd
);

  qualT   qual;
  strobeT strobe;

  pciCmdControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .newXfer    (newXfer),
    .xferKind   (xferKind),
    .cacheEn    (cacheEn),
    .readLineEn (readLineEn),
    .wrInvEn    (wrInvEn),
    .qual       (qual),
    .endValid   (endValid),
    .endKind    (endKind),
    .strobe     (strobe)
  );

  pciCmdDatapath #(
    .ADDR_W        (ADDR_W),
    .CNT_W         (CNT_W),
    .LSZ_W         (LSZ_W),
    .BURST_W       (BURST_W),
    .MAX_LINE_LOG2 (MAX_LINE_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineSizeDw (lineSizeDw),
    .burstLog2  (burstLog2),
    .addr       (addr),
    .bytesLeft  (bytesLeft),
    .strobe     (strobe),
    .qual       (qual),
    .cmdValid   (cmdValid),
    .cmd        (cmd),
    .lineCmd    (lineCmd)
  );

  a_r3_fetch_plain: assert property (@(posedge clk) disable iff (!rstN)
    (start && xferKind == 2'b01) |=> (cmdValid && cmd == 4'b0110));

  a_r4_no_enable_plain: assert property (@(posedge clk) disable iff (!rstN)
    (start && xferKind == 2'b00 && !readLineEn) |=> (cmd == 4'b0110));

  a_r7_write_family: assert property (@(posedge clk) disable iff (!rstN)
    (start && xferKind[1]) |=> (cmd[2:0] == 3'b111));

endmodule

// File: tb/pciCmdSelect_test.sv
module pciCmdSelect_test;

  typedef struct {
    logic [3:0] cmd;
    logic       line;
    string      tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        newXfer = 1'b0;
  logic [1:0]  xferKind = 2'b00;
  logic        cacheEn = 1'b0;
  logic        readLineEn = 1'b0;
  logic        wrInvEn = 1'b0;
  logic [7:0]  lineSizeDw = 8'd8;
  logic [2:0]  burstLog2 = 3'd4;
  logic [31:0] addr = '0;
  logic [23:0] bytesLeft = '0;
  logic        endValid = 1'b0;
  logic [1:0]  endKind = 2'b00;
  logic        cmdValid;
  logic [3:0]  cmd;
  logic        lineCmd;

  int errors = 0;
  int checks = 0;
  expT sbq[$];

  always #10 clk = ~clk;

  pciCmdSelect uut (
    .clk(clk), .rstN(rstN), .start(start), .newXfer(newXfer),
    .xferKind(xferKind), .cacheEn(cacheEn), .readLineEn(readLineEn),
    .wrInvEn(wrInvEn), .lineSizeDw(lineSizeDw), .burstLog2(burstLog2),
    .addr(addr), .bytesLeft(bytesLeft), .endValid(endValid),
    .endKind(endKind), .cmdValid(cmdValid), .cmd(cmd), .lineCmd(lineCmd)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard whenever a command appears.
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R2 unexpected command", {28'd0, cmd}, 32'd0);
      end else begin
        expT e;
        e = sbq.pop_front();
        check(cmd == e.cmd, e.tag, {28'd0, cmd}, {28'd0, e.cmd});
        check(lineCmd == e.line, {"R11 line flag / ", e.tag}, {31'd0, lineCmd}, {31'd0, e.line});
      end
    end
  end

  task automatic issue(input logic [1:0] kind, input logic cEn, input logic rlEn,
                       input logic wiEn, input logic [7:0] lsz, input logic [2:0] blog,
                       input logic [31:0] a, input logic [23:0] b,
                       input logic [3:0] expCmd, input string tag);
    expT e;
    @(negedge clk);
    xferKind = kind; cacheEn = cEn; readLineEn = rlEn; wrInvEn = wiEn;
    lineSizeDw = lsz; burstLog2 = blog; addr = a; bytesLeft = b;
    start = 1'b1;
    e.cmd = expCmd; e.line = expCmd[3]; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(cmdValid == 1'b0, {"R2 one-cycle valid / ", tag}, {31'd0, cmdValid}, 32'd0);
  endtask

  task automatic endOwn(input logic [1:0] k);
    @(negedge clk);
    endValid = 1'b1; endKind = k;
    @(negedge clk);
    endValid = 1'b0;
  endtask

  task automatic pulseNew();
    @(negedge clk);
    newXfer = 1'b1;
    @(negedge clk);
    newXfer = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmdValid == 1'b0, "R1 reset valid low", {31'd0, cmdValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cmdValid == 1'b0, "R1 idle after reset", {31'd0, cmdValid}, 32'd0);

    // R3 opcode fetch
    issue(2'b01, 1, 1, 1, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0110, "R3 fetch all enables");
    issue(2'b01, 0, 1, 0, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0110, "R3 fetch no cache");
    // R4 cache mode off
    issue(2'b00, 0, 1, 0, 8'd6, 3'd0, 32'h104, 24'd4, 4'b1110, "R4 read line no cache");
    issue(2'b00, 0, 0, 1, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0110, "R4 read no enable");
    // R5 / R6 cache mode on
    issue(2'b00, 1, 1, 0, 8'd8, 3'd4, 32'h100, 24'd64, 4'b1110, "R5 size below burst");
    issue(2'b00, 1, 1, 0, 8'd16, 3'd4, 32'h100, 24'd64, 4'b1110, "R5 size equals burst");
    issue(2'b00, 1, 1, 0, 8'd32, 3'd4, 32'h100, 24'd64, 4'b0110, "R5 size above burst");
    issue(2'b00, 1, 0, 0, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0110, "R5 enable off");
    issue(2'b00, 1, 1, 0, 8'd6, 3'd7, 32'h100, 24'd64, 4'b0110, "R6 size 6 illegal");
    issue(2'b00, 1, 1, 0, 8'd1, 3'd7, 32'h100, 24'd64, 4'b0110, "R6 size 1 illegal");
    issue(2'b00, 1, 1, 0, 8'd128, 3'd7, 32'h100, 24'd64, 4'b1110, "R6 size 128 legal");
    issue(2'b00, 1, 1, 0, 8'd2, 3'd1, 32'h100, 24'd64, 4'b1110, "R6 size 2 legal");
    // R7 writes, line 8 dwords = 32 bytes
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h100, 24'd32, 4'b1111, "R7 exact full line");
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h100, 24'd31, 4'b0111, "R7 short by one byte");
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h104, 24'd64, 4'b0111, "R7 misaligned");
    issue(2'b11, 1, 0, 0, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0111, "R7 enable off");
    issue(2'b10, 0, 0, 1, 8'd8, 3'd4, 32'h100, 24'd64, 4'b0111, "R7 cache off");
    issue(2'b10, 1, 0, 1, 8'd12, 3'd4, 32'h000, 24'd64, 4'b0111, "R7 illegal size");
    // R8 retry forces reissue
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h200, 24'd64, 4'b1111, "R8 first inv");
    endOwn(2'b01);
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h204, 24'd4, 4'b1111, "R8 forced after retry");
    // R10 completion clears
    endOwn(2'b00);
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h204, 24'd4, 4'b0111, "R10 cleared by completion");
    // R10 newXfer clears
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h200, 24'd64, 4'b1111, "R10 setup inv");
    endOwn(2'b01);
    pulseNew();
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h204, 24'd4, 4'b0111, "R10 cleared by newXfer");
    // R8 retry after a plain write does not force
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h204, 24'd4, 4'b0111, "R8 plain write setup");
    endOwn(2'b01);
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h204, 24'd4, 4'b0111, "R8 retry after plain write");
    // R9 disconnect
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h200, 24'd64, 4'b1111, "R9 setup inv");
    endOwn(2'b10);
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h210, 24'd48, 4'b0111, "R9 resume misaligned");
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h200, 24'd64, 4'b1111, "R9 setup inv again");
    endOwn(2'b10);
    issue(2'b10, 1, 0, 1, 8'd8, 3'd4, 32'h220, 24'd32, 4'b1111, "R9 resume aligned");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R2 missing commands", sbq.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule